// File: doc/BRIEF.md
# Eight-Channel Edge-Aligned PWM Timer

This block produces eight pulse-width-modulated outputs that all share a single period. One 16-bit up-counter sets that period. It counts from a programmable starting value up to a programmable modulo value and then starts again. Each of the eight channels compares the live count against its own compare value and drives a high-true, edge-aligned pulse. The counter can take its ticks from one of three sources: the system clock, a fixed-rate enable strobe, or an external enable strobe. A power-of-two prescaler divides the chosen source by 1 to 128. The counter can also be stopped.

Software reaches the block through a simple word-addressed register port. Writes take effect on the clock edge. Reads return data combinationally for the address that is presented. Each channel's output passes through three gates: a mode field in its own control register, an enable bit in the common control word, and an output-mask register. The mask comes out of reset with every channel masked. A polarity register can invert any channel, and it also sets that channel's inactive level.

Top module: `pwm8_timer`

## Requirements
- R1: After reset, every output is low, the counter reads 0, the common control word reads 0, and the output-mask register (word address 0x60) reads 0xFF.
- R2: Registers sit at fixed byte addresses and read back the bits they store. Common control is at 0x00, with clock source in bits [4:3], prescale exponent in bits [2:0] and channel n's enable in bit 16+n. The counter is at 0x04, modulo at 0x08 and initial count at 0x4C. Channel n's control is at 0x0C+8n, storing bits [5:2], and its compare value is at 0x10+8n. The mask is at 0x60 and polarity at 0x70. Any other address reads 0.
- R3: Clock source 0 halts the counter. Source 1 advances it on every clock. Source 2 advances it on cycles where `fixed_tick` is high, and source 3 on cycles where `ext_tick` is high.
- R4: With prescale exponent PS, the counter advances once every 2^PS qualifying source cycles.
- R5: On an advance, a counter that is at or above the modulo value loads the initial count. Otherwise it increments by one.
- R6: Writing any value to the counter address loads the initial count on that edge, whatever the data.
- R7: A channel in PWM mode is high while initial count <= count < compare value. A compare value above the modulo holds it high, and a compare value of 0 holds it low.
- R8: A channel is in PWM mode only when bits 5 and 3 of its control register are both 1. Otherwise the channel sits at its inactive level.
- R9: Polarity bit n set to 1 inverts channel n's output. The inactive level of channel n equals its polarity bit.
- R10: Mask bit n set to 1 forces channel n to its inactive level.
- R11: Common control bit 16+n set to 0 forces channel n to its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fixed_tick | input | 1 | Fixed-rate count enable strobe (source 2) |
| ext_tick | input | 1 | External count enable strobe (source 3) |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pwm_out | output | 8 | Channel outputs |

## Verification
The bench targets five corner cases:
- **Compare-value extremes (0 and above modulo).** A design that mishandles these would produce a one-tick glitch or a missing full-on pulse.
- **Modulo lowered below the running count.** An equality-only wrap would let the counter run away through all 65536 values.
- **Counter write with non-zero data.** A wrong design would load that data instead of the initial count.
- **Prescale changes across the whole 1 to 128 range.** An off-by-one divider would drift the period.
- **The interaction of mask, enable, mode bits and polarity.** This shows whether a gated channel idles at its polarity level or wrongly at 0.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;

  localparam int CNT_W = 16;
  localparam int PS_W  = 3;
  localparam int DIV_W = (1 << PS_W) - 1;
  localparam int CTL_W = 4;   // stored channel control bits [5:2]
  localparam int CTL_LSB = 2;

  // word indices (byte address >> 2)
  localparam int W_CTRL    = 0;
  localparam int W_CNT     = 1;
  localparam int W_MOD     = 2;
  localparam int W_CH_BASE = 3;
  localparam int W_CNTIN   = 19;
  localparam int W_MASK    = 24;
  localparam int W_POL     = 28;

  // control word fields
  localparam int CTRL_PS_LSB  = 0;
  localparam int CTRL_SRC_LSB = 3;
  localparam int CTRL_EN_LSB  = 16;

  // channel control: bit 5 and bit 3 together select high-true edge PWM
  localparam int CH_MODE_HI = 5 - CTL_LSB;
  localparam int CH_EDGE_HI = 3 - CTL_LSB;

  typedef enum logic [1:0] {
    SRC_OFF = 2'd0,
    SRC_SYS = 2'd1,
    SRC_FIX = 2'd2,
    SRC_EXT = 2'd3
  } clk_src_e;

  function automatic logic [DIV_W-1:0] div_limit(input logic [PS_W-1:0] ps);
    logic [DIV_W:0] span;
    span = ((DIV_W+1)'(1) << ps) - (DIV_W+1)'(1);
    return span[DIV_W-1:0];
  endfunction

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cnt,
                                                  input logic [CNT_W-1:0] init,
                                                  input logic [CNT_W-1:0] modv);
    return (cnt >= modv) ? init : cnt + CNT_W'(1);
  endfunction

  function automatic logic raw_active(input logic [CNT_W-1:0] cnt,
                                      input logic [CNT_W-1:0] init,
                                      input logic [CNT_W-1:0] modv,
                                      input logic [CNT_W-1:0] cmp);
    if (cmp > modv) return 1'b1;
    return (cnt >= init) && (cnt < cmp);
  endfunction

endpackage

// File: rtl/pwm8_prescaler.sv
module pwm8_prescaler
  import pwm8_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  clk_src_e        src,
  input  logic [PS_W-1:0] ps,
  input  logic            fixed_tick,
  input  logic            ext_tick,
  output logic            sel_edge,
  output logic            tick
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] limit;

  assign limit = div_limit(ps);

  always_comb begin
    unique case (src)
      SRC_SYS: sel_edge = 1'b1;
      SRC_FIX: sel_edge = fixed_tick;
      SRC_EXT: sel_edge = ext_tick;
      default: sel_edge = 1'b0;
    endcase
  end

  assign tick = sel_edge && (div_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              div_q <= '0;
    else if (src == SRC_OFF) div_q <= '0;
    else if (sel_edge)       div_q <= tick ? '0 : div_q + DIV_W'(1);
  end

endmodule

// File: rtl/pwm8_counter.sv
module pwm8_counter
  import pwm8_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             reload,
  input  logic [CNT_W-1:0] init,
  input  logic [CNT_W-1:0] modv,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  assign wrap = tick && !reload && (cnt >= modv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (reload) cnt <= init;
    else if (tick)   cnt <= next_count(cnt, init, modv);
  end

endmodule

// File: rtl/pwm8_channel.sv
module pwm8_channel
  import pwm8_pkg::*;
(
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] init,
  input  logic [CNT_W-1:0] modv,
  input  logic [CNT_W-1:0] cmp,
  input  logic [CTL_W-1:0] ctl,
  input  logic             chan_en,
  input  logic             masked,
  input  logic             invert,
  output logic             pwm_mode,
  output logic             pwm
);

  logic active;
  logic raw;

  assign pwm_mode = ctl[CH_MODE_HI] & ctl[CH_EDGE_HI];
  assign active   = pwm_mode & chan_en & ~masked;
  assign raw      = raw_active(cnt, init, modv, cmp);
  assign pwm      = active ? (raw ^ invert) : invert;

endmodule

// File: rtl/pwm8_timer.sv
module pwm8_timer
  import pwm8_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fixed_tick,
  input  logic              ext_tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCH-1:0]    pwm_out
);

  localparam int WORD_W = ADDR_W - 2;
  localparam logic [31:0] CTRL_KEEP =
    (32'((1 << NCH) - 1) << CTRL_EN_LSB) | 32'h0000_001F;

  logic [WORD_W-1:0] word;
  logic [31:0]       ctrl_q;
  logic [CNT_W-1:0]  mod_q, cntin_q, cnt_q;
  logic [NCH-1:0]    pol_q, mask_q, chan_en;
  logic [CTL_W-1:0]  ch_ctl_q [NCH];
  logic [CNT_W-1:0]  ch_cv_q  [NCH];
  logic [NCH-1:0]    ch_mode;
  logic [1:0]        src_sel;
  logic [PS_W-1:0]   ps_sel;
  logic              cnt_wr, cnt_tick, cnt_wrap, sel_edge;

  assign word    = bus_addr[ADDR_W-1:2];
  assign src_sel = ctrl_q[CTRL_SRC_LSB +: 2];
  assign ps_sel  = ctrl_q[CTRL_PS_LSB +: PS_W];
  assign chan_en = ctrl_q[CTRL_EN_LSB +: NCH];
  assign cnt_wr  = bus_wr && (int'(word) == W_CNT);

  // common registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      mod_q   <= '0;
      cntin_q <= '0;
      pol_q   <= '0;
      mask_q  <= '1;
    end else if (bus_wr) begin
      unique case (int'(word))
        W_CTRL:  ctrl_q  <= bus_wdata & CTRL_KEEP;
        W_MOD:   mod_q   <= bus_wdata[CNT_W-1:0];
        W_CNTIN: cntin_q <= bus_wdata[CNT_W-1:0];
        W_POL:   pol_q   <= bus_wdata[NCH-1:0];
        W_MASK:  mask_q  <= bus_wdata[NCH-1:0];
        default: ;
      endcase
    end
  end

  pwm8_prescaler u_presc (
    .clk        (clk),
    .rst_n      (rst_n),
    .src        (clk_src_e'(src_sel)),
    .ps         (ps_sel),
    .fixed_tick (fixed_tick),
    .ext_tick   (ext_tick),
    .sel_edge   (sel_edge),
    .tick       (cnt_tick)
  );

  pwm8_counter u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (cnt_tick),
    .reload (cnt_wr),
    .init   (cntin_q),
    .modv   (mod_q),
    .cnt    (cnt_q),
    .wrap   (cnt_wrap)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic ctl_wr, cv_wr;
    assign ctl_wr = bus_wr && (int'(word) == W_CH_BASE + 2*n);
    assign cv_wr  = bus_wr && (int'(word) == W_CH_BASE + 2*n + 1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ch_ctl_q[n] <= '0;
        ch_cv_q[n]  <= '0;
      end else begin
        if (ctl_wr) ch_ctl_q[n] <= bus_wdata[CTL_LSB +: CTL_W];
        if (cv_wr)  ch_cv_q[n]  <= bus_wdata[CNT_W-1:0];
      end
    end

    pwm8_channel u_ch (
      .cnt      (cnt_q),
      .init     (cntin_q),
      .modv     (mod_q),
      .cmp      (ch_cv_q[n]),
      .ctl      (ch_ctl_q[n]),
      .chan_en  (chan_en[n]),
      .masked   (mask_q[n]),
      .invert   (pol_q[n]),
      .pwm_mode (ch_mode[n]),
      .pwm      (pwm_out[n])
    );
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    unique case (int'(word))
      W_CTRL:  bus_rdata = ctrl_q;
      W_CNT:   bus_rdata = 32'(cnt_q);
      W_MOD:   bus_rdata = 32'(mod_q);
      W_CNTIN: bus_rdata = 32'(cntin_q);
      W_POL:   bus_rdata = 32'(pol_q);
      W_MASK:  bus_rdata = 32'(mask_q);
      default: ;
    endcase
    for (int n = 0; n < NCH; n++) begin
      if (int'(word) == W_CH_BASE + 2*n)
        bus_rdata = 32'(ch_ctl_q[n]) << CTL_LSB;
      if (int'(word) == W_CH_BASE + 2*n + 1)
        bus_rdata = 32'(ch_cv_q[n]);
    end
  end

endmodule

// File: rtl/pwm8_timer_chk.sv
module pwm8_timer_chk
  import pwm8_pkg::*;
#(
  parameter int NCH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       src_sel,
  input logic             cnt_tick,
  input logic             cnt_wr,
  input logic             cnt_wrap,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] mod_q,
  input logic [CNT_W-1:0] cntin_q,
  input logic [NCH-1:0]   pol_q,
  input logic [NCH-1:0]   mask_q,
  input logic [NCH-1:0]   chan_en,
  input logic [NCH-1:0]   pwm_out
);

  AST_STOP_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'd0) |-> !cnt_tick); // R3

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_tick && !cnt_wr) |=> $stable(cnt_q)); // R3

  AST_WRAP_TO_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wrap |=> (cnt_q == $past(cntin_q))); // R5

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && !cnt_wr && (cnt_q < mod_q)) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R5

  AST_WR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_q == $past(cntin_q))); // R6

  AST_MASK_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwm_out ^ pol_q) & mask_q) == '0); // R10

  AST_ENABLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwm_out ^ pol_q) & ~chan_en) == '0); // R11

endmodule

bind pwm8_timer pwm8_timer_chk #(.NCH(NCH)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .src_sel  (src_sel),
  .cnt_tick (cnt_tick),
  .cnt_wr   (cnt_wr),
  .cnt_wrap (cnt_wrap),
  .cnt_q    (cnt_q),
  .mod_q    (mod_q),
  .cntin_q  (cntin_q),
  .pol_q    (pol_q),
  .mask_q   (mask_q),
  .chan_en  (chan_en),
  .pwm_out  (pwm_out)
);

// File: tb/pwm8_timer_tb_top.sv
`timescale 1ns/1ps
module pwm8_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fixed_tick = 1'b0;
  logic        ext_tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pwm_out;

  always #4 clk = ~clk; // 125 MHz

  pwm8_timer dut_i (
    .clk(clk), .rst_n(rst_n), .fixed_tick(fixed_tick), .ext_tick(ext_tick),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference state
  int unsigned m_ctrl, m_cnt, m_mod, m_cntin, m_pol, m_mask, m_div;
  int unsigned m_chc [8];
  int unsigned m_cv  [8];
  int unsigned s_src, s_lim, s_word, s_cnt, s_div;
  bit          s_edge, s_tick;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_cnt = 0; m_mod = 0; m_cntin = 0; m_pol = 0; m_mask = 'hFF; m_div = 0;
      foreach (m_chc[i]) begin m_chc[i] = 0; m_cv[i] = 0; end
    end else begin
      s_src  = (m_ctrl >> 3) & 3;
      s_lim  = (1 << (m_ctrl & 7)) - 1;
      s_edge = (s_src == 1) || (s_src == 2 && fixed_tick) || (s_src == 3 && ext_tick);
      s_tick = s_edge && (m_div >= s_lim);
      if (s_src == 0) s_div = 0;
      else if (s_edge) s_div = s_tick ? 0 : m_div + 1;
      else s_div = m_div;
      s_word = bus_addr >> 2;
      s_cnt = m_cnt;
      if (bus_wr && s_word == 1) s_cnt = m_cntin;
      else if (s_tick) s_cnt = (m_cnt >= m_mod) ? m_cntin : ((m_cnt + 1) & 'hFFFF);
      if (bus_wr) begin
        case (s_word)
          0:  m_ctrl  = bus_wdata & 'h00FF_001F;
          2:  m_mod   = bus_wdata & 'hFFFF;
          19: m_cntin = bus_wdata & 'hFFFF;
          24: m_mask  = bus_wdata & 'hFF;
          28: m_pol   = bus_wdata & 'hFF;
          default: begin
            if (s_word >= 3 && s_word < 19) begin
              if (((s_word - 3) % 2) == 0) m_chc[(s_word - 3) / 2] = bus_wdata & 'h3C;
              else                         m_cv[(s_word - 3) / 2]  = bus_wdata & 'hFFFF;
            end
          end
        endcase
      end
      m_cnt = s_cnt;
      m_div = s_div;
    end
  end

  function automatic logic [7:0] exp_out();
    logic [7:0] r;
    for (int n = 0; n < 8; n++) begin
      bit on, hi;
      on = ((m_chc[n] & 'h28) == 'h28) && m_ctrl[16+n] && !m_mask[n];
      if (m_cv[n] > m_mod) hi = 1;
      else hi = (m_cnt >= m_cntin) && (m_cnt < m_cv[n]);
      r[n] = on ? (hi ^ m_pol[n]) : m_pol[n];
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    int unsigned w;
    w = a >> 2;
    case (w)
      0: return m_ctrl;
      1: return m_cnt;
      2: return m_mod;
      19: return m_cntin;
      24: return m_mask;
      28: return m_pol;
      default: begin
        if (w >= 3 && w < 19)
          return ((w - 3) % 2 == 0) ? m_chc[(w - 3) / 2] : m_cv[(w - 3) / 2];
        return 0;
      end
    endcase
  endfunction

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    #1;
    if (!done) begin
      logic [7:0]  eo;
      logic [31:0] er;
      eo = rst_n ? exp_out() : 8'h00;
      er = rst_n ? exp_rd(bus_addr) : ((bus_addr == 8'h60) ? 32'hFF : 32'h0);
      checks++;
      if (pwm_out !== eo) begin
        failures++;
        $display("FAIL %s pwm_out actual=%h expected=%h t=%0t", cur_req, pwm_out, eo, $time);
      end
      checks++;
      if (bus_rdata !== er) begin
        failures++;
        $display("FAIL %s rdata@%h actual=%h expected=%h t=%0t", cur_req, bus_addr, bus_rdata, er, $time);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk);
    bus_addr = a;
  endtask

  localparam logic [31:0] EN_MOST = 32'h00BF_0000;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    bus_addr = 8'h60;
    idle(3);
    rst_n = 1'b1;
    rd(8'h60); idle(2);
    rd(8'h00); idle(2);
    rd(8'h04); idle(2);

    // R2: register map and readback
    cur_req = "R2";
    wr(8'h08, 32'hFFFF_0009);
    wr(8'h4C, 32'h0000_0000);
    wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C);       // stores only bits [5:2]
    wr(8'h0C, 32'h28); wr(8'h10, 3);          // ch0 duty 3
    wr(8'h14, 32'h28); wr(8'h18, 0);          // ch1 0%
    wr(8'h1C, 32'h28); wr(8'h20, 20);         // ch2 above modulo
    wr(8'h24, 32'h28); wr(8'h28, 5);          // ch3 inverted
    wr(8'h2C, 32'h20); wr(8'h30, 5);          // ch4 lacks bit 3 (R8)
    wr(8'h34, 32'h28); wr(8'h38, 4);          // ch5 masked
    wr(8'h3C, 32'h28); wr(8'h40, 6);          // ch6 enable off
    wr(8'h44, 32'h08); wr(8'h48, 2);          // ch7 lacks bit 5 (R8)
    wr(8'h70, 32'h88);
    wr(8'h60, 32'h20);
    for (int a = 0; a < 32; a++) begin
      rd(8'(a * 4)); idle(1);
    end
    rd(8'h50); idle(1);
    rd(8'h74); idle(1);

    // R3 / R7 / R8: system clock, prescale 1
    cur_req = "R7";
    wr(8'h00, EN_MOST | 32'h08);
    rd(8'h04);
    idle(40);

    // R4: prescaler range
    cur_req = "R4";
    wr(8'h00, EN_MOST);
    wr(8'h00, EN_MOST | 32'h0A);
    rd(8'h04); idle(100);
    wr(8'h00, EN_MOST);
    wr(8'h00, EN_MOST | 32'h0F);
    rd(8'h04); idle(700);
    wr(8'h00, EN_MOST);

    // R3: fixed and external strobes, then stop
    cur_req = "R3";
    wr(8'h00, EN_MOST | 32'h10);
    for (int i = 0; i < 80; i++) begin
      @(negedge clk); fixed_tick = (i % 3 == 0); ext_tick = 1'b1;
    end
    fixed_tick = 1'b0;
    wr(8'h00, EN_MOST | 32'h19);
    for (int i = 0; i < 120; i++) begin
      @(negedge clk); ext_tick = ($urandom_range(0, 1) == 1); fixed_tick = 1'b1;
    end
    fixed_tick = 1'b0; ext_tick = 1'b0;
    wr(8'h00, EN_MOST);
    rd(8'h04); idle(30);

    // R6: counter write reloads the initial count
    cur_req = "R6";
    wr(8'h00, EN_MOST | 32'h08);
    idle(5);
    wr(8'h04, 32'h1234);
    idle(3);
    wr(8'h4C, 2);
    idle(4);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04); idle(20);

    // R5: initial count, lowered modulo, zero modulo
    cur_req = "R5";
    wr(8'h4C, 4);
    wr(8'h08, 12);
    rd(8'h04); idle(30);
    wr(8'h08, 2);
    idle(10);
    wr(8'h4C, 0);
    idle(10);
    wr(8'h08, 0);
    idle(10);
    wr(8'h08, 9);
    idle(25);

    // R9: polarity
    cur_req = "R9";
    wr(8'h70, 32'hFF); idle(25);
    wr(8'h70, 32'h00); idle(25);

    // R10: mask
    cur_req = "R10";
    wr(8'h60, 32'hFF); idle(15);
    wr(8'h70, 32'h5A); idle(15);
    wr(8'h60, 32'h00); idle(25);

    // R11: enables
    cur_req = "R11";
    wr(8'h00, 32'h0000_0008); idle(20);
    wr(8'h00, 32'h00FF_0008); idle(25);

    // R8: switch mode bits on a running channel
    cur_req = "R8";
    wr(8'h0C, 32'h20); idle(12);
    wr(8'h0C, 32'h2C); idle(12);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule